// File: doc/BRIEF.md
# Share-Domain NOT / XOR / AND Gadget

This block computes on bits that are split into shares. A logical bit is held as `M = 2T+1` share bits, and its value is the XOR of all of them. Probing any `T` internal wires in one cycle does not reveal the value. The block computes three results from two shared operands `a` and `b`, all in every cycle:

- a shared NOT of `a`;
- a shared XOR of `a` and `b`;
- a shared AND of `a` and `b`.

The AND uses pairwise products of shares and pairwise random masks, so no single wire depends on every share of an operand. Fresh mask bits arrive from outside on a dedicated port, one bit per unordered share pair. The mask source lies outside this block. It may be a true random source or several pseudo-random generator instances in a deterministic build.

The AND result always goes through one register stage. The parameter `REG_OUT` chooses whether the NOT and XOR results are also registered. When they are, all three results share the same one-cycle latency. The block contains no state machine. Its only state is the output register bank, which is cleared while reset is held.

Top module: `masked_gadget`

## Requirements
- R1: The share count is `M = 2T+1` (T ≥ 1, default 1) and the mask port has `M(M-1)/2` bits. The mask bit for the pair (i,j) with i<j is taken from bit index `i*M - i(i+1)/2 + (j-i-1)`. Pairs are therefore ordered by i first, then j.
- R2: The NOT result inverts share 0 of `a` and copies shares 1..M-1 unchanged, so its recombined value is the inverse of `a`'s value.
- R3: The XOR result share k equals `a[k] ^ b[k]` for every k, independent of the mask port.
- R4: The recombined AND result equals the AND of the recombined operands presented one clock edge earlier.
- R5: Each AND share is computed exactly as follows, and registered:
  - For i<j, z(i,j) is the pair's mask bit.
  - For i<j, z(j,i) = (z(i,j) ^ a_i·b_j) ^ a_j·b_i.
  - c_i = a_i·b_i XORed with z(i,j) for every j≠i.
- R6: With `REG_OUT=0` the NOT and XOR results follow the inputs in the same cycle. With `REG_OUT=1` they appear one clock edge later.
- R7: While `rst_n` is low, every registered output share reads 0.
- R8: Changing only the mask bits, with the operands held, leaves the recombined AND value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the output registers |
| a_sh | input | M | Shares of operand a |
| b_sh | input | M | Shares of operand b |
| rnd | input | M(M-1)/2 | Fresh mask bits, one per share pair |
| not_sh | output | M | Shares of NOT a |
| xor_sh | output | M | Shares of a XOR b |
| and_sh | output | M | Shares of a AND b, one cycle late |

## Verification
The combinational XOR/NOT path and the registered AND path are both live in every cycle. The interesting case is a cycle in which new operands arrive while the AND of the previous operands is still on the output. The bench provokes this by changing operands on every cycle. It then checks that the XOR and NOT shares already reflect the new operands while the AND shares still match the old operands and the old mask bits. A second instance with registered NOT/XOR is checked in the same run, so that all three results line up on the same edge.

// File: rtl/mgad_pkg.sv
package mgad_pkg;

    // Position of the mask bit for unordered pair (i,j), i<j, among M shares.
    function automatic int pair_slot(input int i, input int j, input int m);
        return i * m - (i * (i + 1)) / 2 + (j - i - 1);
    endfunction

endpackage

// File: rtl/mask_not.sv
module mask_not #(
    parameter int M = 3
) (
    input  logic [M-1:0] x,
    output logic [M-1:0] y
);
    for (genvar k = 0; k < M; k++) begin : g_sh
        if (k == 0) begin : g_flip
            assign y[k] = ~x[k];
        end else begin : g_pass
            assign y[k] = x[k];
        end
    end
endmodule

// File: rtl/mask_xor.sv
module mask_xor #(
    parameter int M = 3
) (
    input  logic [M-1:0] x,
    input  logic [M-1:0] w,
    output logic [M-1:0] y
);
    for (genvar k = 0; k < M; k++) begin : g_sh
        assign y[k] = x[k] ^ w[k];
    end
endmodule

// File: rtl/mask_and.sv
module mask_and
    import mgad_pkg::*;
#(
    parameter int M  = 3,
    parameter int NR = M * (M - 1) / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [M-1:0]  a,
    input  logic [M-1:0]  b,
    input  logic [NR-1:0] rnd,
    output logic [M-1:0]  c
);
    logic [M-1:0] zm [M];
    logic [M-1:0] c_next;

    // Pairwise masks: upper triangle is fresh randomness, lower triangle folds
    // in the two cross products with the fixed bracketing.
    always_comb begin
        for (int r = 0; r < M; r++) begin
            for (int q = 0; q < M; q++) begin
                if (r < q) begin
                    zm[r][q] = rnd[pair_slot(r, q, M)];
                end else if (r > q) begin
                    zm[r][q] = (rnd[pair_slot(q, r, M)] ^ (a[q] & b[r])) ^ (a[r] & b[q]);
                end else begin
                    zm[r][q] = 1'b0;
                end
            end
        end
    end

    always_comb begin
        for (int r = 0; r < M; r++) begin
            c_next[r] = a[r] & b[r];
            for (int q = 0; q < M; q++) begin
                if (q != r) begin
                    c_next[r] = c_next[r] ^ zm[r][q];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c <= '0;
        end else begin
            c <= c_next;
        end
    end
endmodule

// File: rtl/masked_gadget.sv
module masked_gadget #(
    parameter int T       = 1,
    parameter bit REG_OUT = 1'b0,
    localparam int M      = 2 * T + 1,
    localparam int NR     = M * (M - 1) / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [M-1:0]  a_sh,
    input  logic [M-1:0]  b_sh,
    input  logic [NR-1:0] rnd,
    output logic [M-1:0]  not_sh,
    output logic [M-1:0]  xor_sh,
    output logic [M-1:0]  and_sh
);
    logic [M-1:0] not_c;
    logic [M-1:0] xor_c;

    mask_not #(.M(M)) u_not (.x(a_sh), .y(not_c));
    mask_xor #(.M(M)) u_xor (.x(a_sh), .w(b_sh), .y(xor_c));

    mask_and #(.M(M), .NR(NR)) u_and (
        .clk  (clk),
        .rst_n(rst_n),
        .a    (a_sh),
        .b    (b_sh),
        .rnd  (rnd),
        .c    (and_sh)
    );

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                not_sh <= '0;
                xor_sh <= '0;
            end else begin
                not_sh <= not_c;
                xor_sh <= xor_c;
            end
        end
    end else begin : g_comb
        assign not_sh = not_c;
        assign xor_sh = xor_c;
    end

    // One cycle of history after reset before $past is trusted.
    logic primed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    // R4: recombined AND equals AND of last cycle's recombined operands.
    p_and_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
        primed |-> (^and_sh) == ((^$past(a_sh)) & (^$past(b_sh))));

    // R7: registered outputs are cleared while reset is held.
    always_comb begin
        if (!rst_n) begin
            p_reset_clear_r7: assert (and_sh == '0);
        end
    end

    if (REG_OUT) begin : g_chk_reg
        // R2, R6: registered NOT recombines to the inverse of last cycle's a.
        p_not_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
            primed |-> (^not_sh) == ~(^$past(a_sh)));
        // R3, R6: registered XOR recombines to last cycle's a^b.
        p_xor_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
            primed |-> (^xor_sh) == ((^$past(a_sh)) ^ (^$past(b_sh))));
    end else begin : g_chk_comb
        // R2: only share 0 is touched by the NOT.
        p_not_upper_r2: assert property (@(posedge clk) disable iff (!rst_n)
            not_sh[M-1:1] == a_sh[M-1:1] && not_sh[0] != a_sh[0]);
        // R3: XOR recombines to a^b in the same cycle.
        p_xor_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (^xor_sh) == ((^a_sh) ^ (^b_sh)));
    end
endmodule

// File: tb/tb_masked_gadget.sv
module tb_masked_gadget;
    localparam int T  = 1;
    localparam int M  = 2 * T + 1;
    localparam int NR = M * (M - 1) / 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [M-1:0]  a = '0, b = '0;
    logic [NR-1:0] rnd = '0;
    logic [M-1:0]  not_sh, xor_sh, and_sh;
    logic [M-1:0]  not_r, xor_r, and_r;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    masked_gadget #(.T(T), .REG_OUT(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .a_sh(a), .b_sh(b), .rnd(rnd),
        .not_sh(not_sh), .xor_sh(xor_sh), .and_sh(and_sh));

    masked_gadget #(.T(T), .REG_OUT(1'b1)) dut_r (
        .clk(clk), .rst_n(rst_n), .a_sh(a), .b_sh(b), .rnd(rnd),
        .not_sh(not_r), .xor_sh(xor_r), .and_sh(and_r));

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    // Model of the share formulas, pairs enumerated i-major then j.
    function automatic logic [M-1:0] model_and(logic [M-1:0] x, logic [M-1:0] y, logic [NR-1:0] r);
        logic [M-1:0] z [M];
        logic [M-1:0] res;
        int k = 0;
        for (int i = 0; i < M; i++) z[i] = '0;
        for (int i = 0; i < M; i++) begin
            for (int j = i + 1; j < M; j++) begin
                z[i][j] = r[k];
                z[j][i] = (r[k] ^ (x[i] & y[j])) ^ (x[j] & y[i]);
                k++;
            end
        end
        for (int i = 0; i < M; i++) begin
            res[i] = x[i] & y[i];
            for (int j = 0; j < M; j++) if (j != i) res[i] ^= z[i][j];
        end
        return res;
    endfunction

    // Drive at negedge, check combinational paths, then registered ones after the edge.
    task automatic apply(input logic [M-1:0] x, input logic [M-1:0] y, input logic [NR-1:0] r);
        @(negedge clk);
        a = x; b = y; rnd = r;
        #1;
        chk("R2 not shares", not_sh, {x[M-1:1], ~x[0]});
        chk("R3 xor shares", xor_sh, x ^ y);
        @(posedge clk);
        #1;
        chk("R5 and shares", and_sh, model_and(x, y, r));
        chk("R4 and value", ^and_sh, (^x) & (^y));
        chk("R6 reg not", not_r, {x[M-1:1], ~x[0]});
        chk("R6 reg xor", xor_r, x ^ y);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R7 and reset", and_sh, '0);
        chk("R7 reg not reset", not_r, '0);
        chk("R7 reg xor reset", xor_r, '0);
        chk("R7 reg and reset", and_r, '0);
    endtask

    task automatic t_not_xor;
        for (int v = 0; v < (1 << M); v++) apply(M'(v), M'(v * 5 + 3), '0);
    endtask

    task automatic t_and_all;
        logic [7:0] lf = 8'hA5;
        for (int x = 0; x < (1 << M); x++) begin
            for (int y = 0; y < (1 << M); y++) begin
                lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
                apply(M'(x), M'(y), NR'(lf));
            end
        end
    endtask

    // R1: one mask bit at a time exposes the pair slot ordering.
    task automatic t_slot_order;
        for (int k = 0; k < NR; k++) apply(M'(3'b101), M'(3'b011), NR'(1 << k));
    endtask

    // R8: masks alone change shares, never the recombined value.
    task automatic t_mask_only;
        for (int r = 0; r < (1 << NR); r++) begin
            apply(M'(3'b110), M'(3'b100), NR'(r));
            chk("R8 value fixed", ^and_sh, 1'b0 & 1'b1);
        end
        for (int r = 0; r < (1 << NR); r++) begin
            apply(M'(3'b100), M'(3'b010), NR'(r));
            chk("R8 value fixed one", ^and_sh, 1'b1);
        end
    endtask

    // R6/R4 concurrency: new operands each cycle, AND lags by one.
    task automatic t_pipeline;
        logic [M-1:0] pa = '0, pb = '0;
        logic [NR-1:0] pr = '0;
        for (int s = 0; s < 12; s++) begin
            logic [M-1:0] na = M'(s * 3 + 1);
            logic [M-1:0] nb = M'(s * 7 + 2);
            logic [NR-1:0] nr = NR'(s * 5);
            @(negedge clk);
            a = na; b = nb; rnd = nr;
            #1;
            chk("R6 xor now", xor_sh, na ^ nb);
            if (s > 0) begin
                chk("R4 and old", and_sh, model_and(pa, pb, pr));
                chk("R6 reg xor old", xor_r, pa ^ pb);
            end
            pa = na; pb = nb; pr = nr;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset;
        @(negedge clk);
        rst_n = 1'b1;
        t_not_xor;
        t_and_all;
        t_slot_order;
        t_mask_only;
        t_pipeline;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule